// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between the bus-facing write logic of a byte-wide flash device and its internal write state machine. Each bus write reaches it as a one-cycle pulse carrying the address and data byte captured at the strobe's rising edge. The decoder follows the one-, two- and three-write command sequences. It selects what a read returns: array data, identifier bytes or the status byte. Completed sequences become single operation requests for the state machine. The request carries an operation code, the address of the final write and a 16-bit data field.

Operation requests leave through a valid/ready interface. A request stays valid with a frozen payload until the consumer accepts it in a cycle with `op_ready` high. While a request waits, new operations are refused. Only the status-read command still acts. The bus side cannot stall, so writes that are refused are dropped without effect. Status-flag clearing and sequence errors appear as plain one-cycle pulses.

The two-byte write assembles a 16-bit word. Address bit 10 of the first data write picks the half that receives the first byte. The second byte goes to the other half.

Top module: `flash_cui_top`

## Requirements
- R1: After reset, `read_mode` is 0 (array), `op_valid` is 0, and `seq_err` and `clr_flags` are 0.
- R2: With the state machine idle, command FFh sets `read_mode` to 0 (array), 90h sets it to 1 (identifier) and 70h sets it to 2 (status). In identifier mode, `id_byte` is B0h when `rd_a0`=0 and 21h when `rd_a0`=1.
- R3: 40h or 10h followed by one more write issues op type 1 (byte program). Its `op_addr` is that write's address and its `op_data` is {00h, byte}. `read_mode` then becomes 2.
- R4: 20h followed by D0h issues op type 2 (block erase), and A7h followed by D0h issues op type 3 (erase all unlocked). `op_addr` is the address of the confirm write and `read_mode` becomes 2.
- R5: 57h, 47h or 77h, each followed by D0h, issue op types 4 (protect set), 5 (protect clear) and 6 (lock block) respectively, with `op_addr` from the confirm write.
- R6: In any two-write confirm sequence, a second byte other than D0h raises `seq_err` for exactly one cycle. It issues no op, sets `read_mode` to 2 and returns the decoder to idle.
- R7: FBh, then byte X at an address with bit 10 = h, then byte Y at address A, issues op type 7 at A. Its `op_data` holds X in the high half if h=1 or the low half if h=0, and Y in the other half.
- R8: Command 50h pulses `clr_flags` for exactly one cycle and leaves `read_mode` unchanged.
- R9: While `wsm_busy` is 1 and `erase_susp` is 0, only 70h (status mode) and B0h (op type 8, suspend) are accepted. Every other write changes neither `read_mode` nor `op_valid`.
- R10: While `erase_susp` is 1, FFh selects array mode, 70h selects status mode and D0h issues op type 9 (resume). All other writes, including 90h and B0h, are ignored.
- R11: A valid op holds `op_valid` and its payload stable until accepted with `op_ready`=1. While it waits, only 70h is accepted. A suspend or resume op carries {00h, command byte} in `op_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | One-cycle pulse per captured bus write |
| bus_addr | input | 19 | Address latched with the write |
| bus_data | input | 8 | Command or data byte of the write |
| rd_a0 | input | 1 | Read address bit 0 for identifier selection |
| wsm_busy | input | 1 | Write state machine running an operation |
| erase_susp | input | 1 | Erase currently suspended |
| op_valid | output | 1 | Operation request pending |
| op_ready | input | 1 | Consumer accepts the request |
| op_type | output | 4 | Operation code 1..9 |
| op_addr | output | 19 | Address of the completing write |
| op_data | output | 16 | Data byte or assembled word |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |
| id_byte | output | 8 | Identifier byte in identifier mode, else 00h |
| seq_err | output | 1 | One-cycle pulse on a bad confirm byte |
| clr_flags | output | 1 | One-cycle pulse to clear status error flags |

## Verification
Each command sequence is driven with the state machine idle, busy, suspended and with a request held back by `op_ready`. This shows that acceptance depends on those conditions and not on the command alone. The two-byte write is tried with bit 10 both clear and set, which tells a correct complement placement from a fixed or mirrored one. A bad confirm byte followed by a lone D0h shows that the decoder really falls back to idle. A scoreboard of expected requests exposes missing, extra or reordered operations.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_e;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_PROG      = 4'd1,
    OP_ERASE_BLK = 4'd2,
    OP_ERASE_ALL = 4'd3,
    OP_PROT_SET  = 4'd4,
    OP_PROT_CLR  = 4'd5,
    OP_LOCK_BLK  = 4'd6,
    OP_PROG_WORD = 4'd7,
    OP_SUSPEND   = 4'd8,
    OP_RESUME    = 4'd9
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_ERASE, S_ERALL, S_PSET, S_PCLR, S_LOCK, S_TB1, S_TB2
  } seq_e;

  localparam logic [7:0] C_READ   = 8'hFF;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_STAT   = 8'h70;
  localparam logic [7:0] C_CLR    = 8'h50;
  localparam logic [7:0] C_PROG_A = 8'h40;
  localparam logic [7:0] C_PROG_B = 8'h10;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_ERALL  = 8'hA7;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_PSET   = 8'h57;
  localparam logic [7:0] C_PCLR   = 8'h47;
  localparam logic [7:0] C_LOCK   = 8'h77;
  localparam logic [7:0] C_TWO    = 8'hFB;

  function automatic op_e conf_op(seq_e s);
    case (s)
      S_ERASE: return OP_ERASE_BLK;
      S_ERALL: return OP_ERASE_ALL;
      S_PSET:  return OP_PROT_SET;
      S_PCLR:  return OP_PROT_CLR;
      default: return OP_LOCK_BLK;
    endcase
  endfunction

endpackage

// File: rtl/cui_cmd_fsm.sv
module cui_cmd_fsm
  import flash_cui_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wsm_busy,
  input  logic       erase_susp,
  input  logic       op_pend,
  output logic       issue,
  output op_e        issue_op,
  output logic       first_ld,
  output rmode_e     mode,
  output logic       seq_err,
  output logic       clr_flags
);

  seq_e   st_q, st_d;
  rmode_e mode_d;
  logic   err_d, clr_d;
  logic   locked;

  assign locked = wsm_busy | erase_susp | op_pend;

  always_comb begin
    st_d     = st_q;
    mode_d   = mode;
    issue    = 1'b0;
    issue_op = OP_NONE;
    first_ld = 1'b0;
    err_d    = 1'b0;
    clr_d    = 1'b0;
    if (wr_en) begin
      unique case (st_q)
        S_IDLE: begin
          if (locked) begin
            if (wr_data == C_STAT) begin
              mode_d = RM_STATUS;
            end else if (!op_pend && erase_susp && wr_data == C_READ) begin
              mode_d = RM_ARRAY;
            end else if (!op_pend && erase_susp && wr_data == C_CONF) begin
              issue = 1'b1; issue_op = OP_RESUME; mode_d = RM_STATUS;
            end else if (!op_pend && !erase_susp && wr_data == C_SUSP) begin
              issue = 1'b1; issue_op = OP_SUSPEND; mode_d = RM_STATUS;
            end
          end else begin
            case (wr_data)
              C_READ:            mode_d = RM_ARRAY;
              C_IDENT:           mode_d = RM_IDENT;
              C_STAT:            mode_d = RM_STATUS;
              C_CLR:             clr_d  = 1'b1;
              C_PROG_A, C_PROG_B: st_d  = S_PROG;
              C_ERASE:           st_d   = S_ERASE;
              C_ERALL:           st_d   = S_ERALL;
              C_PSET:            st_d   = S_PSET;
              C_PCLR:            st_d   = S_PCLR;
              C_LOCK:            st_d   = S_LOCK;
              C_TWO:             st_d   = S_TB1;
              default: ;
            endcase
          end
        end
        S_PROG: begin
          issue = 1'b1; issue_op = OP_PROG; st_d = S_IDLE; mode_d = RM_STATUS;
        end
        S_ERASE, S_ERALL, S_PSET, S_PCLR, S_LOCK: begin
          st_d   = S_IDLE;
          mode_d = RM_STATUS;
          if (wr_data == C_CONF) begin
            issue = 1'b1; issue_op = conf_op(st_q);
          end else begin
            err_d = 1'b1;
          end
        end
        S_TB1: begin
          first_ld = 1'b1; st_d = S_TB2;
        end
        S_TB2: begin
          issue = 1'b1; issue_op = OP_PROG_WORD; st_d = S_IDLE; mode_d = RM_STATUS;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      mode      <= RM_ARRAY;
      seq_err   <= 1'b0;
      clr_flags <= 1'b0;
    end else begin
      st_q      <= st_d;
      mode      <= mode_d;
      seq_err   <= err_d;
      clr_flags <= clr_d;
    end
  end

  // R2
  ident_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RM_IDENT && $past(mode) != RM_IDENT) |-> $past(wr_en && wr_data == C_IDENT));

  // R6
  seq_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);

  // R11
  no_issue_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !op_pend);

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_busy && !erase_susp && st_q == S_IDLE && wr_en && wr_data != C_SUSP) |-> !issue);

endmodule

// File: rtl/cui_word_asm.sv
module cui_word_asm #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            first_ld,
  input  logic            half_sel,
  input  logic [BW-1:0]   byte_in,
  output logic [2*BW-1:0] word_out
);

  logic [BW-1:0] keep_q;
  logic          half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= '0;
      half_q <= 1'b0;
    end else if (first_ld) begin
      keep_q <= byte_in;
      half_q <= half_sel;
    end
  end

  // first byte sits in the half chosen by half_q, live byte fills the other
  always_comb begin
    if (half_q) word_out = {keep_q, byte_in};
    else        word_out = {byte_in, keep_q};
  end

endmodule

// File: rtl/cui_op_hold.sv
module cui_op_hold
  import flash_cui_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  op_e           ld_type,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          valid,
  input  logic          ready,
  output op_e           typ,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      typ   <= OP_NONE;
      addr  <= '0;
      data  <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (load) begin
        valid <= 1'b1;
        typ   <= ld_type;
        addr  <= ld_addr;
        data  <= ld_data;
      end
    end
  end

  // R11
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);

  // R11
  payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> ($stable(typ) && $stable(addr) && $stable(data)));

  // R11
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid);

endmodule

// File: rtl/flash_cui_top.sv
module flash_cui_top
  import flash_cui_pkg::*;
#(
  parameter int          AW       = 19,
  parameter int          BW       = 8,
  parameter int          HALF_BIT = 10,
  parameter logic [7:0]  MFR_ID   = 8'hB0,
  parameter logic [7:0]  DEV_ID   = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BW-1:0]     bus_data,
  input  logic              rd_a0,
  input  logic              wsm_busy,
  input  logic              erase_susp,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [3:0]        op_type,
  output logic [AW-1:0]     op_addr,
  output logic [2*BW-1:0]   op_data,
  output logic [1:0]        read_mode,
  output logic [7:0]        id_byte,
  output logic              seq_err,
  output logic              clr_flags
);

  localparam int DW = 2 * BW;

  logic          issue, first_ld;
  op_e           issue_op, held_op;
  rmode_e        mode;
  logic [DW-1:0] word, ld_data;

  cui_cmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_we),
    .wr_data   (bus_data),
    .wsm_busy  (wsm_busy),
    .erase_susp(erase_susp),
    .op_pend   (op_valid),
    .issue     (issue),
    .issue_op  (issue_op),
    .first_ld  (first_ld),
    .mode      (mode),
    .seq_err   (seq_err),
    .clr_flags (clr_flags)
  );

  cui_word_asm #(.BW(BW)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .first_ld(first_ld),
    .half_sel(bus_addr[HALF_BIT]),
    .byte_in (bus_data),
    .word_out(word)
  );

  assign ld_data = (issue_op == OP_PROG_WORD) ? word : {{BW{1'b0}}, bus_data};

  cui_op_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (issue),
    .ld_type(issue_op),
    .ld_addr(bus_addr),
    .ld_data(ld_data),
    .valid  (op_valid),
    .ready  (op_ready),
    .typ    (held_op),
    .addr   (op_addr),
    .data   (op_data)
  );

  assign op_type   = held_op;
  assign read_mode = mode;
  assign id_byte   = (mode == RM_IDENT) ? (rd_a0 ? DEV_ID : MFR_ID) : 8'h00;

endmodule

// File: tb/flash_cui_top_tb_top.sv
`timescale 1ns/1ps
module flash_cui_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [18:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        rd_a0 = 1'b0;
  logic        wsm_busy = 1'b0;
  logic        erase_susp = 1'b0;
  logic        op_valid;
  logic        op_ready = 1'b1;
  logic [3:0]  op_type;
  logic [18:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  read_mode;
  logic [7:0]  id_byte;
  logic        seq_err, clr_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       req;
    logic [3:0]  t;
    logic [18:0] a;
    logic [15:0] d;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  flash_cui_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_data(bus_data), .rd_a0(rd_a0), .wsm_busy(wsm_busy),
    .erase_susp(erase_susp), .op_valid(op_valid), .op_ready(op_ready),
    .op_type(op_type), .op_addr(op_addr), .op_data(op_data),
    .read_mode(read_mode), .id_byte(id_byte), .seq_err(seq_err),
    .clr_flags(clr_flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [18:0] a);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_data = d; bus_addr = a;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic push(input string req, input logic [3:0] t, input logic [18:0] a, input logic [15:0] d);
    exp_t e;
    e.req = req; e.t = t; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  // monitor: pop expected request at each accepted transfer
  always @(negedge clk) begin
    if (rst_n && op_valid && op_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard unexpected op act=%0h exp=none", op_type);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.req, " type"}, {28'd0, op_type}, {28'd0, e.t});
        chk({e.req, " addr"}, {13'd0, op_addr}, {13'd0, e.a});
        chk({e.req, " data"}, {16'd0, op_data}, {16'd0, e.d});
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mode", read_mode, 0);
    chk("R1 valid", op_valid, 0);
    chk("R1 err", seq_err, 0);
    rst_n = 1'b1;

    // R2 read modes and identifier bytes
    wr(8'h90, 0);
    chk("R2 ident mode", read_mode, 1);
    rd_a0 = 1'b0; #1;
    chk("R2 mfr id", id_byte, 8'hB0);
    rd_a0 = 1'b1; #1;
    chk("R2 dev id", id_byte, 8'h21);
    wr(8'h70, 0);
    chk("R2 status mode", read_mode, 2);
    wr(8'hFF, 0);
    chk("R2 array mode", read_mode, 0);

    // R3 byte program, both command codes
    wr(8'h40, 0);
    push("R3", 4'd1, 19'h12345, 16'h005A);
    wr(8'h5A, 19'h12345);
    chk("R3 status after prog", read_mode, 2);
    wr(8'h10, 0);
    push("R3", 4'd1, 19'h00007, 16'h00C3);
    wr(8'hC3, 19'h00007);

    // R4 erases
    wr(8'h20, 0);
    push("R4", 4'd2, 19'h1C000, 16'h00D0);
    wr(8'hD0, 19'h1C000);
    wr(8'hA7, 0);
    push("R4", 4'd3, 19'h00000, 16'h00D0);
    wr(8'hD0, 19'h00000);

    // R5 protect and lock sequences
    wr(8'h57, 0);
    push("R5", 4'd4, 19'h000FF, 16'h00D0);
    wr(8'hD0, 19'h000FF);
    wr(8'h47, 0);
    push("R5", 4'd5, 19'h000FF, 16'h00D0);
    wr(8'hD0, 19'h000FF);
    wr(8'h77, 0);
    push("R5", 4'd6, 19'h44000, 16'h00D0);
    wr(8'hD0, 19'h44000);

    // R6 bad confirm byte
    wr(8'hFF, 0);
    wr(8'h20, 0);
    wr(8'h55, 19'h08000);
    chk("R6 err pulse", seq_err, 1);
    chk("R6 no op", op_valid, 0);
    chk("R6 status mode", read_mode, 2);
    @(posedge clk); #1;
    chk("R6 err one cycle", seq_err, 0);
    wr(8'hD0, 19'h08000);
    chk("R6 back to idle", op_valid, 0);

    // R7 two-byte write, first byte low then high
    wr(8'hFB, 0);
    wr(8'h11, 19'h00000);
    push("R7", 4'd7, 19'h30010, 16'h2211);
    wr(8'h22, 19'h30010);
    wr(8'hFB, 0);
    wr(8'hAA, 19'h00400);
    push("R7", 4'd7, 19'h30020, 16'hAA55);
    wr(8'h55, 19'h30020);

    // R8 clear flags
    wr(8'hFF, 0);
    wr(8'h50, 0);
    chk("R8 clr pulse", clr_flags, 1);
    chk("R8 mode kept", read_mode, 0);
    @(posedge clk); #1;
    chk("R8 clr one cycle", clr_flags, 0);

    // R9 busy refusal
    wsm_busy = 1'b1;
    wr(8'h90, 0);
    chk("R9 ident refused", read_mode, 0);
    wr(8'h40, 0);
    wr(8'h33, 19'h00100);
    chk("R9 prog refused", op_valid, 0);
    wr(8'h70, 0);
    chk("R9 status ok", read_mode, 2);
    wr(8'hFF, 0);
    chk("R9 array refused", read_mode, 2);
    push("R9", 4'd8, 19'h00003, 16'h00B0);
    wr(8'hB0, 19'h00003);
    wsm_busy = 1'b0;

    // R10 suspended behaviour
    erase_susp = 1'b1;
    wr(8'hFF, 0);
    chk("R10 array ok", read_mode, 0);
    wr(8'h90, 0);
    chk("R10 ident refused", read_mode, 0);
    wr(8'hB0, 0);
    chk("R10 suspend refused", op_valid, 0);
    wr(8'h70, 0);
    chk("R10 status ok", read_mode, 2);
    push("R10", 4'd9, 19'h00005, 16'h00D0);
    wr(8'hD0, 19'h00005);
    erase_susp = 1'b0;

    // R11 back-pressure
    wr(8'hFF, 0);
    op_ready = 1'b0;
    wr(8'h40, 0);
    wr(8'h9C, 19'h2ABCD);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 valid held", op_valid, 1);
    chk("R11 addr held", op_addr, 19'h2ABCD);
    chk("R11 data held", op_data, 16'h009C);
    wr(8'h90, 0);
    chk("R11 ident refused", read_mode, 2);
    wr(8'hFF, 0);
    chk("R11 array refused", read_mode, 2);
    push("R11", 4'd1, 19'h2ABCD, 16'h009C);
    op_ready = 1'b1;
    @(posedge clk); #1;
    chk("R11 released", op_valid, 0);

    repeat (4) @(posedge clk);
    #1;
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule